// File: doc/BRIEF.md
# Serial Transmit Sequencer with Per-Format Pin Release

This block is the transmit half of a synchronous serial port operating as clock master. A parallel word of 4 to `MAX_W` bits is loaded in one system clock, then shifted out most significant bit first. It is framed in one of three styles: select-low (SPI-like), select-low with early pin release (Microwire-like), or a one-period frame pulse ahead of the word (TI-SSP-like).

Besides the serial clock, frame and data, the block drives an output-enable for the data pin. When the tristate option is on, that enable rises and falls at points in the sequence that depend on the chosen style, so the pin floats between words. A configurable end-of-word level is driven during a short tail slot after the last bit.

All timing comes from one system clock. A divider produces half-period strobes every `HALF_DIV` clocks, and every output change is registered on one of those strobes.

Top module: `ser_tx_ctrl`

## Requirements
- R1: `len_i` gives the word length as a bit count from 4 to `MAX_W`. Bits `data_i[len_i-1:0]` are sent MSB first, and higher bits are ignored. Each bit spans one serial period: a low half then a high half, each `HALF_DIV` clocks long. `sclk_o` idles low and changes only at half-period boundaries. A bit is launched at load or at a falling edge.
- R2: While `tri_en_i` is 0, `txd_oe_o` is 1 at every cycle, in every format and while idle.
- R3: Format code 2'b00 (and 2'b11, which behaves the same) holds `frame_o` low from load until the end of the tail slot, and then raises it. With `tri_en_i` set, `txd_oe_o` is high exactly while `frame_o` is low in this format.
- R4: After the falling edge that ends the LSB, there is one tail half-period before the block goes idle. During the tail, and while idle afterwards, `txd_o` equals the `idle_lvl_i` value captured at load.
- R5: Format code 2'b01 raises `txd_oe_o` at load together with the MSB. It drops `txd_oe_o` at the rising `sclk_o` edge inside the LSB, one edge after the edge that launched it. `frame_o` behaves as in R3.
- R6: Format code 2'b10 drives `frame_o` high for one full serial period before the MSB, and low otherwise. `txd_oe_o` stays low during that pulse and rises with the MSB at the falling edge that ends the pulse.
- R7: In format 2'b10 with `late_park_i` set, `txd_oe_o` stays high through the tail slot and falls at its end. With `late_park_i` clear, it falls at the falling edge that ends the LSB.
- R8: `late_park_i` has no effect in formats 2'b00 and 2'b01.
- R9: `busy_o` is high from the cycle after `start_i` is accepted until the end of the tail slot. The pin enable driven by the sequence is never high while `busy_o` is low.
- R10: `start_i` is ignored while `busy_o` is high: the running word, its timing and its length are unchanged, and no second word follows.
- R11: After reset: `sclk_o` 0, `frame_o` 1, `txd_o` 0, `busy_o` 0, and `txd_oe_o` 0 when `tri_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a word; accepted only while idle |
| data_i | input | MAX_W | Word to send, right-justified |
| len_i | input | LW | Word length in bits (4..MAX_W) |
| fmt_i | input | 2 | Frame style: 00 SPI-like, 01 Microwire-like, 10 TI-like, 11 as 00 |
| tri_en_i | input | 1 | Let the data pin float outside its driven window |
| late_park_i | input | 1 | TI-like style: hold the pin enable through the tail slot |
| idle_lvl_i | input | 1 | Data level for the tail slot and idle, captured at load |
| sclk_o | output | 1 | Serial clock |
| frame_o | output | 1 | Frame / select |
| txd_o | output | 1 | Serial data value |
| txd_oe_o | output | 1 | Output enable for the data pin |
| busy_o | output | 1 | Word in progress |

## Verification
The embedded properties assume that `len_i` lies in 4..`MAX_W` whenever a start is accepted. They also assume the configuration is sampled only at load, so later changes to `fmt_i`, `late_park_i` or `idle_lvl_i` during a word do not matter to them. The stimulus always loads a legal length and holds the configuration steady until `busy_o` falls. Its only mid-word input activity is a deliberate start pulse with altered data. The bench derives every expected waveform from the slot count alone: the frame lead, two slots per bit and one tail slot. It compares at each clock across all three styles, both lengths at the extremes, and both tristate settings.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    FMT_SPI = 2'b00,
    FMT_MW  = 2'b01,
    FMT_TI  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_TAIL
  } st_e;
endpackage

// File: rtl/ser_tx_tick.sv
module ser_tx_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int MAX_W = 32,
  parameter int LW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [MAX_W-1:0] data_i,
  input  logic [LW-1:0]    len_i,
  output logic             msb_o
);
  logic [MAX_W-1:0] sr_q;
  logic [LW-1:0]    pad;

  // left-justify so the first bit sent is always sr_q[MAX_W-1]
  assign pad = LW'(MAX_W) - len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i << pad;
    else if (shift_i) sr_q <= {sr_q[MAX_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[MAX_W-1];
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    fmt_i,
  input  logic [LW-1:0] len_i,
  input  logic          late_park_i,
  input  logic          idle_lvl_i,
  input  logic          tick_i,
  output logic          load_o,
  output logic          shift_o,
  output logic          in_data_o,
  output logic          idle_lvl_o,
  output logic          sclk_o,
  output logic          frame_o,
  output logic          oe_o,
  output logic          busy_o
);
  st_e           st_q;
  fmt_e          fmt_q;
  logic          ph_q, sclk_q, frame_q, oe_q, late_q, lvl_q;
  logic [LW-1:0] bits_q;
  logic          last_bit;

  assign last_bit = (bits_q == '0);
  assign load_o   = start_i && (st_q == ST_IDLE);
  assign shift_o  = tick_i && (st_q == ST_DATA) && ph_q && !last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fmt_q   <= FMT_SPI;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
      oe_q    <= 1'b0;
      late_q  <= 1'b0;
      lvl_q   <= 1'b0;
      bits_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          fmt_q  <= fmt_e'(fmt_i);
          late_q <= late_park_i && (fmt_e'(fmt_i) == FMT_TI);
          lvl_q  <= idle_lvl_i;
          bits_q <= len_i - 1'b1;
          ph_q   <= 1'b0;
          sclk_q <= 1'b0;
          if (fmt_e'(fmt_i) == FMT_TI) begin
            st_q    <= ST_LEAD;
            frame_q <= 1'b1;
            oe_q    <= 1'b0;
          end else begin
            st_q    <= ST_DATA;
            frame_q <= 1'b0;
            oe_q    <= 1'b1;
          end
        end
        ST_LEAD: if (tick_i) begin
          if (!ph_q) begin
            sclk_q <= 1'b1;
            ph_q   <= 1'b1;
          end else begin
            sclk_q  <= 1'b0;
            ph_q    <= 1'b0;
            frame_q <= 1'b0;
            oe_q    <= 1'b1;
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: if (tick_i) begin
          if (!ph_q) begin
            sclk_q <= 1'b1;
            ph_q   <= 1'b1;
            if (fmt_q == FMT_MW && last_bit) oe_q <= 1'b0;
          end else begin
            sclk_q <= 1'b0;
            ph_q   <= 1'b0;
            if (last_bit) begin
              st_q <= ST_TAIL;
              if (fmt_q == FMT_TI && !late_q) oe_q <= 1'b0;
            end else begin
              bits_q <= bits_q - 1'b1;
            end
          end
        end
        ST_TAIL: if (tick_i) begin
          st_q    <= ST_IDLE;
          oe_q    <= 1'b0;
          frame_q <= (fmt_q != FMT_TI);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_data_o  = (st_q == ST_DATA);
  assign idle_lvl_o = lvl_q;
  assign sclk_o     = sclk_q;
  assign frame_o    = frame_q;
  assign oe_o       = oe_q;
  assign busy_o     = (st_q != ST_IDLE);

  assert_sclk_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sclk_q));

  assert_spi_oe_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && fmt_q != FMT_MW && fmt_q != FMT_TI) |-> (oe_q && !frame_q));

  assert_mw_release_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == FMT_MW && $fell(oe_q)) |-> sclk_q);

  assert_ti_pulse_floats_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == FMT_TI && frame_q) |-> !oe_q);

  assert_idle_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !oe_q);

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick_i) |=> $stable(bits_q));
endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int MAX_W    = 32,
  parameter int HALF_DIV = 4,
  parameter int LW       = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAX_W-1:0] data_i,
  input  logic [LW-1:0]    len_i,
  input  logic [1:0]       fmt_i,
  input  logic             tri_en_i,
  input  logic             late_park_i,
  input  logic             idle_lvl_i,
  output logic             sclk_o,
  output logic             frame_o,
  output logic             txd_o,
  output logic             txd_oe_o,
  output logic             busy_o
);
  logic tick, load, shift, in_data, lvl, oe_seq, msb;

  ser_tx_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .tick_o(tick)
  );

  ser_tx_shift #(.MAX_W(MAX_W), .LW(LW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .data_i (data_i),
    .len_i  (len_i),
    .msb_o  (msb)
  );

  ser_tx_seq #(.LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .fmt_i      (fmt_i),
    .len_i      (len_i),
    .late_park_i(late_park_i),
    .idle_lvl_i (idle_lvl_i),
    .tick_i     (tick),
    .load_o     (load),
    .shift_o    (shift),
    .in_data_o  (in_data),
    .idle_lvl_o (lvl),
    .sclk_o     (sclk_o),
    .frame_o    (frame_o),
    .oe_o       (oe_seq),
    .busy_o     (busy_o)
  );

  assign txd_o    = in_data ? msb : lvl;
  assign txd_oe_o = !tri_en_i || oe_seq;

  assert_len_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |-> (len_i >= LW'(4) && len_i <= LW'(MAX_W)));
endmodule

// File: tb/ser_tx_ctrl_bench.sv
`timescale 1ns/1ps
module ser_tx_ctrl_bench;
  localparam int MAX_W = 32;
  localparam int HALF  = 4;
  localparam int LW    = $clog2(MAX_W + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [MAX_W-1:0] data_i = '0;
  logic [LW-1:0]    len_i = LW'(8);
  logic [1:0]       fmt_i = 2'b00;
  logic             tri_en_i = 1'b1;
  logic             late_i = 1'b0;
  logic             idle_i = 1'b0;
  logic sclk_o, frame_o, txd_o, oe_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ser_tx_ctrl #(.MAX_W(MAX_W), .HALF_DIV(HALF)) u_ser_tx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .data_i(data_i),
    .len_i(len_i), .fmt_i(fmt_i), .tri_en_i(tri_en_i), .late_park_i(late_i),
    .idle_lvl_i(idle_i), .sclk_o(sclk_o), .frame_o(frame_o), .txd_o(txd_o),
    .txd_oe_o(oe_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // R11
  task automatic t_reset();
    @(negedge clk);
    chk("R11", "reset sclk", sclk_o, 1'b0);
    chk("R11", "reset frame", frame_o, 1'b1);
    chk("R11", "reset txd", txd_o, 1'b0);
    chk("R11", "reset oe", oe_o, 1'b0);
    chk("R11", "reset busy", busy_o, 1'b0);
  endtask

  // one word, compared every clock against a slot-count model
  task automatic t_word(input string tag, input logic [1:0] f, input int n,
                        input logic [31:0] d, input logic te, input logic lp,
                        input logic iv, input int ign_at);
    int lead, tail, total;
    string oe_req;
    lead  = (f == 2'b10) ? 2 : 0;
    tail  = lead + 2 * n;
    total = (tail + 3) * HALF;
    if (!te)             oe_req = "R2";
    else if (f == 2'b01) oe_req = "R5";
    else if (f == 2'b10) oe_req = lp ? "R7" : "R6";
    else                 oe_req = "R3";
    @(negedge clk);
    fmt_i = f; len_i = LW'(n); data_i = d; tri_en_i = te; late_i = lp; idle_i = iv;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < total; c++) begin
      int  s;
      logic e_sclk, e_frame, e_oe, e_busy, e_txd;
      bit  is_pre, is_data;
      s       = c / HALF;
      is_pre  = s < lead;
      is_data = (s >= lead) && (s < tail);
      e_sclk  = (is_pre || is_data) ? logic'((s - lead) % 2) : 1'b0;
      e_busy  = s <= tail;
      if (f == 2'b10) e_frame = is_pre;
      else            e_frame = !(s <= tail);
      if (f == 2'b01)      e_oe = s <= 2 * n - 2;
      else if (f == 2'b10) e_oe = lp ? (s >= lead && s <= tail) : (s >= lead && s < tail);
      else                 e_oe = s <= tail;
      e_oe  = e_oe || !te;
      e_txd = is_data ? d[n - 1 - (s - lead) / 2] : iv;
      chk("R1", {tag, " sclk"}, sclk_o, e_sclk);
      chk((f == 2'b10) ? "R6" : "R3", {tag, " frame"}, frame_o, e_frame);
      chk(oe_req, {tag, " oe"}, oe_o, e_oe);
      chk("R9", {tag, " busy"}, busy_o, e_busy);
      chk(is_data ? "R1" : "R4", {tag, " txd"}, txd_o, e_txd);
      start_i = (c == ign_at);
      if (c == ign_at) begin
        data_i = ~d; len_i = LW'(4);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    if (ign_at >= 0) begin
      repeat (4 * HALF) @(negedge clk);
      chk("R10", {tag, " no queued word"}, busy_o, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_word("R3 spi 8b",            2'b00, 8,  32'h0000_00A5, 1'b1, 1'b0, 1'b1, -1);
    t_word("R8 spi 32b late set",  2'b00, 32, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, -1);
    t_word("R8 mw 4b late set",    2'b01, 4,  32'h0000_0009, 1'b1, 1'b1, 1'b0, -1);
    t_word("R5 mw 12b",            2'b01, 12, 32'h0000_0B3C, 1'b1, 1'b0, 1'b1, -1);
    t_word("R7 ti 16b late",       2'b10, 16, 32'h0000_C35A, 1'b1, 1'b1, 1'b1, -1);
    t_word("R6 ti 5b no late",     2'b10, 5,  32'h0000_0016, 1'b1, 1'b0, 1'b0, -1);
    t_word("R2 spi 6b always on",  2'b00, 6,  32'h0000_002D, 1'b0, 1'b0, 1'b1, -1);
    t_word("R2 ti 4b always on",   2'b10, 4,  32'h0000_0005, 1'b0, 1'b1, 1'b0, -1);
    t_word("R10 spi start in word", 2'b00, 8, 32'h0000_0071, 1'b1, 1'b0, 1'b0, 22);
    t_word("R10 mw start in word", 2'b01, 10, 32'h0000_0255, 1'b1, 1'b0, 1'b1, 9);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule